// File: doc/BRIEF.md
# CRT Controller Register File with Timing-Register Write Lock

This block holds the configuration registers of a CRT display controller behind a two-address host port. The host first writes a register number to the index address. Every later access to the data address then reads or writes the register that this number selects. The stored index stays put, so a string of data accesses keeps hitting the same register until the host loads a new index.

One bit of the vertical-sync-end register (number 0x11, bit 7) acts as a write lock over the low group of horizontal and vertical timing registers (numbers 0x00 to 0x07). While the lock bit is 1, data writes to that group are dropped without any response. The lock register itself always stays writable, so software unlocks the group with a read-modify-write that clears bit 7, and locks it again by setting bit 7. Reads are never blocked.

The contents of every register are driven continuously on a flat parallel bus for the timing generator that sits next to this block. The reset input is asynchronous and active low. Its release passes through a two-stage synchronizer, so the register file leaves reset two clock edges after `rst_n` rises.

Top module: `crtc_regfile`

## Requirements
- R1: A write with `bus_sel`=0 loads `bus_wdata` into the index register on that clock edge. A read with `bus_sel`=0 returns the stored index.
- R2: A write with `bus_sel`=1 stores `bus_wdata` into the register that the index selects, if that register is writable. A read with `bus_sel`=1 returns the stored value in the same cycle.
- R3: The index keeps its value across data reads and data writes, so repeated data accesses reach the same register.
- R4: After reset, registers 0x00 to 0x18 hold 0x00, except register 0x11, which holds 0x80 (lock active). The index reads 0x00.
- R5: While bit 7 of register 0x11 is 1, data writes to registers 0x00 to 0x07 leave those registers unchanged.
- R6: Register 0x11, including bit 7, accepts data writes whatever the lock state. Clearing bit 7 makes registers 0x00 to 0x07 writable again, and setting it locks them again.
- R7: The lock has no effect on writes to registers 0x08 to 0x18.
- R8: Data reads return the stored value of any register from 0x00 to 0x18, whatever the lock state.
- R9: An index of 0x19 or above reads as 0x00 through the data address, and data writes to such an index change no register.
- R10: `crtc_regs[8*n+7:8*n]` always shows the current contents of register n, for n from 0 to 24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_we | input | 1 | Host write strobe, one write per cycle while high |
| bus_sel | input | 1 | Address select: 0 = index address, 1 = data address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data for the address that `bus_sel` selects (combinational) |
| crtc_regs | output | 200 | All 25 registers side by side, register n in bits 8n+7 to 8n |

## Verification
The hardest situation to reach is a write attempt on a protected timing register that comes right after the lock bit has been changed through a read-modify-write of register 0x11. The index has to move from 0x11 to the target register and back, and the old value of the target has to be visible to show that the write was dropped. The bench gets there by first filling the low group with known patterns while the lock is off. It then sets the lock, fires writes with different values at every protected register, and compares the parallel outputs and the data-port read-back against a model kept in the bench. Finally it clears only bit 7 through a read-modify-write, keeping the other bits of register 0x11, and shows that the same writes now take effect.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  parameter int DW        = 8;
  parameter int IW        = 8;
  parameter int NREG      = 25;
  parameter int LOCK_REG  = 17;
  parameter int LOCK_BIT  = 7;
  parameter int LOCK_LAST = 7;
  localparam int FLAT_W   = NREG * DW;
endpackage

// File: rtl/crtc_index_reg.sv
module crtc_index_reg #(
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [IW-1:0] load_val,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (load_en) idx_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign idx_o = idx_q;

  // R1
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> idx_o == $past(load_val));

  // R3
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(idx_o));
endmodule

// File: rtl/crtc_reg_bank.sv
module crtc_reg_bank #(
  parameter int DW        = 8,
  parameter int IW        = 8,
  parameter int NREG      = 25,
  parameter int LOCK_REG  = 17,
  parameter int LOCK_BIT  = 7,
  parameter int LOCK_LAST = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [DW-1:0]      wr_val,
  output logic               locked,
  output logic [NREG*DW-1:0] flat_o
);
  logic [DW-1:0] reg_q [NREG];
  logic [DW-1:0] reg_d [NREG];

  assign locked = reg_q[LOCK_REG][LOCK_BIT];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [IW-1:0] MY_IDX   = IW'(g);
    localparam bit            GUARDED  = (g <= LOCK_LAST);
    localparam logic [DW-1:0] RST_VAL  =
      (g == LOCK_REG) ? DW'(1) << LOCK_BIT : '0;

    logic hit, allow;
    assign hit   = wr_en && (wr_idx == MY_IDX);
    assign allow = hit && !(GUARDED && locked);

    always_comb begin
      reg_d[g] = reg_q[g];
      if (allow) reg_d[g] = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_q[g] <= RST_VAL;
      else        reg_q[g] <= reg_d[g];
    end

    assign flat_o[g*DW +: DW] = reg_q[g];

    if (GUARDED) begin : g_guard_chk
      // R5
      locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == MY_IDX && locked) |=> $stable(flat_o[g*DW +: DW]));
    end else begin : g_free_chk
      // R6 R7
      free_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == MY_IDX) |=> flat_o[g*DW +: DW] == $past(wr_val));
    end
  end

  // R9
  out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx >= IW'(NREG)) |=> $stable(flat_o));
endmodule

// File: rtl/crtc_regfile.sv
module crtc_regfile
  import crtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_sel,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [FLAT_W-1:0] crtc_regs
);
  logic [1:0]    rst_sync_q;
  logic          rst_core_n;
  logic [IW-1:0] cur_idx;
  logic          lock_st;
  logic          idx_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  crtc_index_reg #(.IW(IW)) u_index (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load_en  (bus_we && !bus_sel),
    .load_val (IW'(bus_wdata)),
    .idx_o    (cur_idx)
  );

  crtc_reg_bank #(
    .DW(DW), .IW(IW), .NREG(NREG),
    .LOCK_REG(LOCK_REG), .LOCK_BIT(LOCK_BIT), .LOCK_LAST(LOCK_LAST)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .wr_en  (bus_we && bus_sel),
    .wr_idx (cur_idx),
    .wr_val (bus_wdata),
    .locked (lock_st),
    .flat_o (crtc_regs)
  );

  assign idx_ok = (cur_idx < IW'(NREG));

  always_comb begin
    bus_rdata = '0;
    if (!bus_sel)    bus_rdata = DW'(cur_idx);
    else if (idx_ok) bus_rdata = crtc_regs[cur_idx[4:0]*DW +: DW];
  end

  // R8
  read_path_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_sel && idx_ok) |-> bus_rdata == crtc_regs[cur_idx[4:0]*DW +: DW]);

  // R9
  range_read_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_sel && !idx_ok) |-> bus_rdata == '0);

  // R6
  lock_follow_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_we && bus_sel && cur_idx == IW'(LOCK_REG)) |=> lock_st == $past(bus_wdata[LOCK_BIT]));
endmodule

// File: tb/test_crtc_regfile.sv
`timescale 1ns/1ps
module test_crtc_regfile;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_we;
  logic         bus_sel;
  logic [7:0]   bus_wdata;
  logic [7:0]   bus_rdata;
  logic [199:0] crtc_regs;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [7:0] model [25];

  always #2 clk = ~clk;

  crtc_regfile i_crtc_regfile (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .crtc_regs(crtc_regs)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog: got %0d cycles expected < 20000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(logic sel, logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(logic sel, output logic [7:0] d);
    @(negedge clk);
    bus_sel = sel;
    #1 d = bus_rdata;
  endtask

  task automatic chk_all(string tag);
    for (int n = 0; n < 25; n++) chk(tag, crtc_regs[n*8 +: 8], model[n]);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int n = 0; n < 25; n++) model[n] = 8'h00;
    model[17] = 8'h80;
    chk_all("R4 R10 reset outputs");
    bus_rd(1'b0, v); chk("R4 reset index", v, 8'h00);
    bus_rd(1'b1, v); chk("R4 reset read reg0", v, 8'h00);
  endtask

  task automatic t_index;
    logic [7:0] v;
    bus_wr(1'b0, 8'h0C); bus_rd(1'b0, v); chk("R1 index readback", v, 8'h0C);
    bus_wr(1'b0, 8'hA5); bus_rd(1'b0, v); chk("R1 index any value", v, 8'hA5);
  endtask

  task automatic t_unlock_fill;
    logic [7:0] v;
    bus_wr(1'b0, 8'h11); bus_rd(1'b1, v); chk("R8 read lock reg", v, 8'h80);
    bus_wr(1'b1, (v & 8'h7F) | 8'h05); model[17] = 8'h05;
    bus_rd(1'b1, v); chk("R6 lock cleared", v, 8'h05);
    for (int n = 0; n < 8; n++) begin
      bus_wr(1'b0, 8'(n)); bus_wr(1'b1, 8'(8'h30 + n)); model[n] = 8'(8'h30 + n);
      bus_rd(1'b1, v); chk("R2 unlocked write", v, model[n]);
    end
    chk_all("R10 after fill");
  endtask

  task automatic t_repeat;
    logic [7:0] v;
    bus_wr(1'b0, 8'h09);
    bus_wr(1'b1, 8'h11); bus_wr(1'b1, 8'h22); bus_rd(1'b1, v);
    bus_wr(1'b1, 8'h3C); model[9] = 8'h3C;
    bus_rd(1'b0, v); chk("R3 index kept", v, 8'h09);
    bus_rd(1'b1, v); chk("R3 repeated data write", v, 8'h3C);
    chk_all("R3 R10 outputs");
  endtask

  task automatic t_locked;
    logic [7:0] v;
    bus_wr(1'b0, 8'h11); bus_rd(1'b1, v);
    bus_wr(1'b1, v | 8'h80); model[17] = v | 8'h80;
    bus_rd(1'b1, v); chk("R6 lock set", v, 8'h85);
    for (int n = 0; n < 8; n++) begin
      bus_wr(1'b0, 8'(n)); bus_wr(1'b1, 8'hEE);
      bus_rd(1'b1, v); chk("R5 R8 locked write dropped", v, model[n]);
    end
    bus_wr(1'b0, 8'h08); bus_wr(1'b1, 8'h77); model[8] = 8'h77;
    bus_wr(1'b0, 8'h18); bus_wr(1'b1, 8'h99); model[24] = 8'h99;
    bus_rd(1'b1, v); chk("R7 high reg writable while locked", v, 8'h99);
    bus_wr(1'b0, 8'h11); bus_wr(1'b1, 8'hC3); model[17] = 8'hC3;
    bus_rd(1'b1, v); chk("R6 lock reg writable while locked", v, 8'hC3);
    chk_all("R5 R7 outputs");
  endtask

  task automatic t_relock;
    logic [7:0] v;
    bus_wr(1'b0, 8'h11); bus_rd(1'b1, v);
    bus_wr(1'b1, v & 8'h7F); model[17] = 8'h43;
    bus_wr(1'b0, 8'h03); bus_wr(1'b1, 8'h5A); model[3] = 8'h5A;
    bus_rd(1'b1, v); chk("R6 unlock re-enables", v, 8'h5A);
    bus_wr(1'b0, 8'h11); bus_wr(1'b1, 8'h80); model[17] = 8'h80;
    bus_wr(1'b0, 8'h03); bus_wr(1'b1, 8'h00);
    bus_rd(1'b1, v); chk("R5 relock blocks", v, 8'h5A);
    chk_all("R6 outputs");
  endtask

  task automatic t_range;
    logic [7:0] v;
    bus_wr(1'b0, 8'h19); bus_wr(1'b1, 8'hFF);
    bus_rd(1'b1, v); chk("R9 read 0x19", v, 8'h00);
    bus_wr(1'b0, 8'hFF); bus_wr(1'b1, 8'h12);
    bus_rd(1'b1, v); chk("R9 read 0xFF", v, 8'h00);
    bus_wr(1'b0, 8'h91); bus_wr(1'b1, 8'h00);
    chk_all("R9 no register changed");
  endtask

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_sel = 1'b0; bus_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_index;
    t_unlock_fill;
    t_repeat;
    t_locked;
    t_relock;
    t_range;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule